// File: doc/BRIEF.md
# Prefixed Displacement Address Generator

This block sits in the decode stage of a core that issues one fixed-width 32-bit instruction word per cycle. Some words are constant prefixes: each holds a 26-bit payload meant to widen the displacement of the memory-reference instruction right behind it. The block can hold up to two such prefixes. It joins their payloads to the 13-bit displacement of the next load or store to form a 64-bit immediate. It then adds that immediate to the base register value and to the index register value shifted by the instruction's scale field.

The effective address appears one cycle after the memory instruction is accepted, together with a one-cycle strobe, the access data-type code and a store flag. Some sequences are malformed: a third prefix in a row, or a prefix followed by anything other than a load or store. For these the block raises a one-cycle illegal-sequence pulse and drops whatever prefix payload it held. Register file reads, memory access and the rest of decode happen outside the block.

Instruction layout: bits [31:26] hold the opcode. The prefix opcode is 6'h3E, the load opcode is 6'h20 and the store opcode is 6'h21; every other opcode counts as a non-memory instruction. For a prefix, bits [25:0] are the payload. For a load or store, bits [25:23] are the scale, bits [22:20] are the type code (a store uses only [21:20]), bits [19:13] are register selectors that this block does not use, and bits [12:0] are the displacement.

Top module: `cpx_agen_top`

## Requirements
- R1: While reset is high, and in the cycle after it is released, ea_valid and seq_illegal are 0. No prefix state survives reset.
- R2: A load or store with no prefix before it uses a displacement equal to bits [12:0] sign-extended to 64 bits.
- R3: A load or store with exactly one prefix P before it uses the 39-bit value {P, disp13}, sign-extended from bit 38 to 64 bits.
- R4: A load or store with two prefixes before it (first A, then B) uses {A, B, disp13} truncated to its low 64 bits, which drops the top bit of A.
- R5: The effective address is base_val + (index_val << scale) + displacement, taken modulo 2^64, where scale is word bits [25:23] (0 to 7).
- R6: For a load, ea_dtype equals word bits [22:20] and ea_store is 0. For a store, ea_dtype equals {1'b0, bits [21:20]} and ea_store is 1.
- R7: ea_valid is high for exactly the one cycle after each accepted load or store, and ea_addr, ea_dtype and ea_store hold that instruction's result in that cycle. ea_valid is low at all other times.
- R8: A third prefix accepted while two are already held raises seq_illegal for one cycle, in the next cycle. All held payloads and the third payload are discarded, so the next load or store uses the plain displacement.
- R9: A non-memory instruction accepted while one or two prefixes are held raises seq_illegal for one cycle, in the next cycle, and the held payloads are discarded.
- R10: Prefix payloads apply only to the one load or store that follows them. A later load or store with no new prefix uses the plain displacement.
- R11: A cycle with in_valid low has no effect: no output pulse, and any held prefixes stay in place for the next accepted word.
- R12: A non-memory instruction accepted with no prefix held produces neither ea_valid nor seq_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_word holds an instruction this cycle |
| in_word | input | 32 | Instruction word |
| base_val | input | 64 | Value read from the base register |
| index_val | input | 64 | Value read from the index register |
| ea_valid | output | 1 | Effective address strobe |
| ea_addr | output | 64 | Effective address |
| ea_dtype | output | 3 | Access data-type code |
| ea_store | output | 1 | Access is a store |
| seq_illegal | output | 1 | Malformed prefix sequence seen |

## Verification
Two events can land on the same clock edge. One is clearing the prefix state after a load or store consumes it, or after an illegal sequence discards it. The other is accepting the next word, which may itself be a prefix or another memory instruction. The bench drives fully back-to-back streams with no bubbles: two-prefix loads followed at once by a new prefix, third-prefix errors followed at once by a load, and loads directly after loads. Each result is judged against a bench model of the prefix count, so a clear that swallows the following prefix, or a leftover payload that leaks into the next displacement, shows up as a wrong address or a misplaced strobe.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    localparam int INSN_W  = 32;
    localparam int OP_W    = 6;
    localparam int PAY_W   = 26;
    localparam int DISP_W  = 13;
    localparam int SCALE_W = 3;
    localparam int TYPE_W  = 3;
    localparam int SEL_W   = INSN_W - OP_W - SCALE_W - TYPE_W - DISP_W;
    localparam int MAX_PFX = 2;
    localparam int CNT_W   = $clog2(MAX_PFX + 1);

    localparam logic [OP_W-1:0] OP_PREFIX = 6'h3E;
    localparam logic [OP_W-1:0] OP_LOAD   = 6'h20;
    localparam logic [OP_W-1:0] OP_STORE  = 6'h21;

    typedef enum logic [1:0] {
        K_PREFIX = 2'd0,
        K_LOAD   = 2'd1,
        K_STORE  = 2'd2,
        K_OTHER  = 2'd3
    } word_kind_e;

    typedef struct packed {
        logic [OP_W-1:0]    op;
        logic [SCALE_W-1:0] scale;
        logic [TYPE_W-1:0]  dtype;
        logic [SEL_W-1:0]   sel;
        logic [DISP_W-1:0]  disp;
    } mem_word_t;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [PAY_W-1:0] payload;
    } pfx_word_t;

    function automatic word_kind_e classify(input logic [OP_W-1:0] op);
        word_kind_e k;
        if (op == OP_PREFIX)     k = K_PREFIX;
        else if (op == OP_LOAD)  k = K_LOAD;
        else if (op == OP_STORE) k = K_STORE;
        else                     k = K_OTHER;
        return k;
    endfunction

    function automatic logic is_mem(input word_kind_e k);
        return (k == K_LOAD) || (k == K_STORE);
    endfunction

endpackage

// File: rtl/cpx_prefix_track.sv
module cpx_prefix_track
    import cpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                acc,
    input  word_kind_e          kind,
    input  logic [PAY_W-1:0]    payload,
    output logic [CNT_W-1:0]    held,
    output logic [PAY_W-1:0]    pay_first,
    output logic [PAY_W-1:0]    pay_second,
    output logic                illegal
);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PAY_W-1:0] p0_q, p1_q;
    logic             ill_q, ill_d;
    logic             cap0, cap1;

    always_comb begin
        cnt_d = cnt_q;
        ill_d = 1'b0;
        cap0  = 1'b0;
        cap1  = 1'b0;
        if (acc) begin
            unique case (kind)
                K_PREFIX: begin
                    if (cnt_q == CNT_W'(MAX_PFX)) begin
                        ill_d = 1'b1;
                        cnt_d = '0;
                    end else begin
                        cap0  = (cnt_q == '0);
                        cap1  = (cnt_q == CNT_W'(1));
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                K_LOAD, K_STORE: cnt_d = '0;
                default: begin
                    ill_d = (cnt_q != '0);
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            p0_q  <= '0;
            p1_q  <= '0;
            ill_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ill_q <= ill_d;
            if (cap0) p0_q <= payload;
            if (cap1) p1_q <= payload;
        end
    end

    assign held       = cnt_q;
    assign pay_first  = p0_q;
    assign pay_second = p1_q;
    assign illegal    = ill_q;

    // R8
    held_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_PFX));

    // R10
    consume_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && is_mem(kind)) |=> (cnt_q == '0));

    // R11
    bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> ($stable(cnt_q) && !ill_q));

endmodule

// File: rtl/cpx_imm_build.sv
module cpx_imm_build
    import cpx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [CNT_W-1:0]  held,
    input  logic [PAY_W-1:0]  pay_first,
    input  logic [PAY_W-1:0]  pay_second,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   imm
);

    localparam int ONE_W = PAY_W + DISP_W;
    localparam int TWO_W = 2 * PAY_W + DISP_W;

    logic [ONE_W-1:0] one_w;
    logic [TWO_W-1:0] two_w;
    logic [XLEN-1:0]  imm0, imm1, imm2;

    assign one_w = {pay_first, disp};
    assign two_w = {pay_first, pay_second, disp};

    assign imm0 = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
    assign imm1 = {{(XLEN-ONE_W){one_w[ONE_W-1]}}, one_w};

    generate
        if (TWO_W >= XLEN) begin : g_trunc
            assign imm2 = two_w[XLEN-1:0];
        end else begin : g_sext
            assign imm2 = {{(XLEN-TWO_W){two_w[TWO_W-1]}}, two_w};
        end
    endgenerate

    always_comb begin
        unique case (held)
            CNT_W'(0): imm = imm0;
            CNT_W'(1): imm = imm1;
            default:   imm = imm2;
        endcase
    end

endmodule

// File: rtl/cpx_agu.sv
module cpx_agu
    import cpx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic                is_store,
    input  logic [SCALE_W-1:0]  scale,
    input  logic [TYPE_W-1:0]   dtype_raw,
    input  logic [XLEN-1:0]     base_val,
    input  logic [XLEN-1:0]     index_val,
    input  logic [XLEN-1:0]     imm,
    output logic                valid,
    output logic [XLEN-1:0]     addr,
    output logic [TYPE_W-1:0]   dtype,
    output logic                store
);

    logic [XLEN-1:0]   scaled;
    logic [XLEN-1:0]   sum;
    logic [TYPE_W-1:0] dtype_n;

    assign scaled  = index_val << scale;
    assign sum     = base_val + scaled + imm;
    assign dtype_n = is_store ? {1'b0, dtype_raw[TYPE_W-2:0]} : dtype_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            dtype <= '0;
            store <= 1'b0;
        end else begin
            valid <= fire;
            if (fire) begin
                addr  <= sum;
                dtype <= dtype_n;
                store <= is_store;
            end
        end
    end

    // R6
    store_type_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && store) |-> (dtype[TYPE_W-1] == 1'b0));

endmodule

// File: rtl/cpx_agen_top.sv
module cpx_agen_top
    import cpx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     in_word,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] index_val,
    output logic            ea_valid,
    output logic [XLEN-1:0] ea_addr,
    output logic [2:0]      ea_dtype,
    output logic            ea_store,
    output logic            seq_illegal
);

    mem_word_t        mw;
    pfx_word_t        pw;
    word_kind_e       kind;
    logic [CNT_W-1:0] held;
    logic [PAY_W-1:0] pay_first, pay_second;
    logic [XLEN-1:0]  imm;
    logic             fire;

    assign mw   = mem_word_t'(in_word);
    assign pw   = pfx_word_t'(in_word);
    assign kind = classify(mw.op);
    assign fire = in_valid && is_mem(kind);

    cpx_prefix_track u_track (
        .clk        (clk),
        .rst        (rst),
        .acc        (in_valid),
        .kind       (kind),
        .payload    (pw.payload),
        .held       (held),
        .pay_first  (pay_first),
        .pay_second (pay_second),
        .illegal    (seq_illegal)
    );

    cpx_imm_build #(.XLEN(XLEN)) u_imm (
        .held       (held),
        .pay_first  (pay_first),
        .pay_second (pay_second),
        .disp       (mw.disp),
        .imm        (imm)
    );

    cpx_agu #(.XLEN(XLEN)) u_agu (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .is_store   (kind == K_STORE),
        .scale      (mw.scale),
        .dtype_raw  (mw.dtype),
        .base_val   (base_val),
        .index_val  (index_val),
        .imm        (imm),
        .valid      (ea_valid),
        .addr       (ea_addr),
        .dtype      (ea_dtype),
        .store      (ea_store)
    );

    // R7
    strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> $past(in_valid && (in_word[31:26] == OP_LOAD || in_word[31:26] == OP_STORE)));

    // R7
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
        !(ea_valid && seq_illegal));

    // R12
    quiet_other_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == K_OTHER && held == '0) |=> (!ea_valid && !seq_illegal));

endmodule

// File: tb/cpx_agen_top_tb_top.sv
`timescale 1ns/1ps
module cpx_agen_top_tb_top;

    typedef struct {
        bit          v;
        bit          ill;
        logic [63:0] addr;
        logic [2:0]  dt;
        bit          st;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [63:0] base_val = '0;
    logic [63:0] index_val = '0;
    logic        ea_valid;
    logic [63:0] ea_addr;
    logic [2:0]  ea_dtype;
    logic        ea_store;
    logic        seq_illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    exp_t q[$];

    int          m_cnt = 0;
    logic [25:0] m_p0 = '0, m_p1 = '0;

    always #2.5 clk = ~clk;

    cpx_agen_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .base_val(base_val), .index_val(index_val), .ea_valid(ea_valid),
        .ea_addr(ea_addr), .ea_dtype(ea_dtype), .ea_store(ea_store),
        .seq_illegal(seq_illegal)
    );

    function automatic logic [31:0] w_pfx(input logic [25:0] p);
        return {6'h3E, p};
    endfunction

    function automatic logic [31:0] w_mem(input bit st, input logic [2:0] sc,
                                          input logic [2:0] dt, input logic [12:0] d);
        return {(st ? 6'h21 : 6'h20), sc, dt, 7'h55, d};
    endfunction

    function automatic logic [31:0] w_oth();
        return {6'h05, 26'h123_4567};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] ex);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, ex);
        end
    endtask

    task automatic send(input bit vld, input logic [31:0] w, input logic [63:0] b,
                        input logic [63:0] x, input string req);
        exp_t e;
        logic [5:0]  op;
        logic [63:0] im;
        e.v = 0; e.ill = 0; e.addr = '0; e.dt = '0; e.st = 0; e.req = req;
        op = w[31:26];
        in_valid  = vld;
        in_word   = w;
        base_val  = b;
        index_val = x;
        if (vld) begin
            if (op == 6'h3E) begin
                if (m_cnt == 2) begin e.ill = 1; m_cnt = 0; end
                else if (m_cnt == 0) begin m_p0 = w[25:0]; m_cnt = 1; end
                else begin m_p1 = w[25:0]; m_cnt = 2; end
            end else if (op == 6'h20 || op == 6'h21) begin
                if (m_cnt == 0)      im = 64'(signed'(w[12:0]));
                else if (m_cnt == 1) im = 64'(signed'({m_p0, w[12:0]}));
                else                 im = (64'(m_p0) << 39) | (64'(m_p1) << 13) | 64'(w[12:0]);
                e.v    = 1;
                e.st   = (op == 6'h21);
                e.dt   = e.st ? {1'b0, w[21:20]} : w[22:20];
                e.addr = b + (x << w[25:23]) + im;
                m_cnt  = 0;
            end else begin
                e.ill = (m_cnt != 0);
                m_cnt = 0;
            end
        end
        @(posedge clk);
        q.push_back(e);
        #1;
    endtask

    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(ea_valid == e.v, e.req, "ea_valid", 64'(ea_valid), 64'(e.v));
            check(seq_illegal == e.ill, e.req, "seq_illegal", 64'(seq_illegal), 64'(e.ill));
            if (e.v) begin
                check(ea_addr == e.addr, e.req, "ea_addr", ea_addr, e.addr);
                check(ea_dtype == e.dt, e.req, "ea_dtype", 64'(ea_dtype), 64'(e.dt));
                check(ea_store == e.st, e.req, "ea_store", 64'(ea_store), 64'(e.st));
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet during reset
        check(!ea_valid && !seq_illegal, "R1", "reset outputs", {62'b0, ea_valid, seq_illegal}, 64'h0);
        rst = 1'b0;
        // R1: first memory op after reset sees no prefix
        send(1, w_mem(0, 3'd0, 3'd3, 13'h0010), 64'h1000, 64'h0, "R1");
        // R2: negative plain displacement, R5 scale 3
        send(1, w_mem(0, 3'd3, 3'd5, 13'h1FF0), 64'h8000, 64'h4, "R2");
        // R6: store type code with bit 22 set in the word
        send(1, w_mem(1, 3'd1, 3'd7, 13'h0FFF), 64'h20, 64'h3, "R6");
        // R3: one prefix, positive and negative payloads
        send(1, w_pfx(26'h000_1234), 64'h0, 64'h0, "R3");
        send(1, w_mem(0, 3'd2, 3'd1, 13'h0ABC), 64'h100, 64'h10, "R3");
        send(1, w_pfx(26'h3FF_FFF0), 64'h0, 64'h0, "R3");
        send(1, w_mem(1, 3'd0, 3'd2, 13'h1000), 64'h0, 64'h0, "R3");
        // R4: two prefixes, top payload bit dropped; followed at once by a prefix
        send(1, w_pfx(26'h2AB_CDEF), 64'h0, 64'h0, "R4");
        send(1, w_pfx(26'h155_5555), 64'h0, 64'h0, "R4");
        send(1, w_mem(0, 3'd7, 3'd4, 13'h1234), 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        send(1, w_pfx(26'h000_0001), 64'h0, 64'h0, "R4");
        send(1, w_mem(0, 3'd0, 3'd0, 13'h0000), 64'h0, 64'h0, "R4");
        // R10: next memory op has no prefix
        send(1, w_mem(1, 3'd5, 3'd3, 13'h1FFF), 64'hFFFF_FFFF_0000_0000, 64'h7, "R10");
        // R5: wraparound modulo 2^64
        send(1, w_mem(0, 3'd4, 3'd6, 13'h0001), 64'hFFFF_FFFF_FFFF_FFF0, 64'h1, "R5");
        // R8: third prefix, then load right away
        send(1, w_pfx(26'h111_1111), 64'h0, 64'h0, "R8");
        send(1, w_pfx(26'h222_2222), 64'h0, 64'h0, "R8");
        send(1, w_pfx(26'h333_3333), 64'h0, 64'h0, "R8");
        send(1, w_mem(0, 3'd0, 3'd2, 13'h0040), 64'h500, 64'h0, "R8");
        // R9: prefix then non-memory, then store
        send(1, w_pfx(26'h0AA_AAAA), 64'h0, 64'h0, "R9");
        send(1, w_oth(), 64'h0, 64'h0, "R9");
        send(1, w_mem(1, 3'd1, 3'd1, 13'h0008), 64'h40, 64'h2, "R9");
        send(1, w_pfx(26'h001_0000), 64'h0, 64'h0, "R9");
        send(1, w_pfx(26'h002_0000), 64'h0, 64'h0, "R9");
        send(1, w_oth(), 64'h0, 64'h0, "R9");
        // R12: non-memory with nothing held
        send(1, w_oth(), 64'h0, 64'h0, "R12");
        send(1, w_mem(0, 3'd0, 3'd1, 13'h0002), 64'h10, 64'h0, "R12");
        // R11: bubbles keep the held prefix, even with a mem-looking word present
        send(1, w_pfx(26'h000_0ABC), 64'h0, 64'h0, "R11");
        send(0, w_mem(0, 3'd0, 3'd0, 13'h0000), 64'h0, 64'h0, "R11");
        send(0, w_oth(), 64'h0, 64'h0, "R11");
        send(1, w_mem(0, 3'd1, 3'd0, 13'h0003), 64'h2000, 64'h8, "R11");
        // R7: strobe drops after a single cycle
        send(0, 32'h0, 64'h0, 64'h0, "R7");
        send(0, 32'h0, 64'h0, 64'h0, "R7");
        repeat (2) @(negedge clk);
        check(q.size() == 0, "R7", "pending results", 64'(q.size()), 64'h0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule